// File: doc/BRIEF.md
# Instruction/Data Address Translation Path with Fault Checking

This block turns a 64-bit virtual address into a physical address for one memory request, and it classifies the outcome with a fault code. A request can skip translation in two ways. In the first, the caller marks it physical. In the second, it falls inside a kernel-only superpage window. Any other request is checked for a well-formed virtual address and then looked up in a small fully associative translation buffer. That lookup is keyed by the virtual page number and the current address-space number. Every mapped result then passes a range check against the implemented physical address width.

The result is registered. It appears one cycle after `req_valid_i`, with `valid_o` as its strobe. The translation buffer is loaded through a simple fill port, which replaces entries in round-robin order. Read and write counters track translated accesses, successful results and access violations. Page-table walking and cacheability decisions belong to other blocks.

Top module: `addr_xlate_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. `paddr_o`, `fault_o` and `status_o` keep their last value while no request completes.
- R2: After reset, `valid_o`, `paddr_o`, `fault_o`, `status_o` and all counters are zero, the translation buffer holds no valid entry and the replacement pointer is at entry 0.
- R3: A superpage hit occurs when `sp_en_i[1]` is 1 and `va_i[42:41]` is 2'b10. If `mode_i` is kernel (2'b00), the request is treated as physical: `paddr_o` = `va_i` AND the implemented mask (bits below PA_IMPL_W), and `fault_o` is 0 (none).
- R4: A superpage hit with `mode_i` not kernel gives `fault_o` = 1 (access violation) and `paddr_o` = 0. This check takes priority even when `phys_i` is set.
- R5: With `phys_i` set and no superpage hit, `paddr_o` = `va_i` AND the implemented mask and `fault_o` = 0. No virtual-address validity check is applied.
- R6: On the translated path, a virtual address is valid only when `va_i[63:43]` are all copies of `va_i[42]`. An invalid address gives `fault_o` = 1 with `paddr_o` = 0.
- R7: On the translated path, a valid entry whose VPN equals `va_i[42:13]` and whose ASN equals `asn_i` hits. The lowest-numbered matching entry wins. `paddr_o` = zero-extended {PFN, `va_i[12:0]`}. With no hit, `fault_o` = 2 (miss) and `paddr_o` = 0.
- R8: A translated result with any bit at or above PA_IMPL_W set (default 44) gives `fault_o` = 3 (machine check), and `paddr_o` still shows that address.
- R9: `status_o` bit 2 is the write flag, bit 1 is bad virtual address and bit 0 is access violation. On fault 1 or 2, bit 2 equals `is_write_i`. Bit 0 is set on fault 1 only, and bit 1 only for an invalid virtual address. On fault 0 or 3, `status_o` is zero.
- R10: `fill_en_i` writes {VPN, ASN, PFN} into the entry at the replacement pointer and marks it valid. The pointer then advances by one, wrapping after the last entry. A lookup in the same cycle as a fill sees the contents from before that fill.
- R11: The read or write access counter increments only for requests on the translated path, meaning those that are neither superpage nor physical. This includes requests that then fault.
- R12: The read or write hit counter increments for every request with `fault_o` = 0, whether the address was mapped or bypassed.
- R13: The read or write access-violation counter increments for every request with `fault_o` = 1. All counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| va_i | input | 64 | Virtual address |
| phys_i | input | 1 | Request already physical |
| is_write_i | input | 1 | Store (1) or load/fetch (0) |
| mode_i | input | 2 | Current privilege mode, 2'b00 = kernel |
| sp_en_i | input | 2 | Superpage enable field, bit 1 enables the window |
| asn_i | input | 8 | Current address-space number |
| fill_en_i | input | 1 | Translation buffer write strobe |
| fill_vpn_i | input | 30 | VPN to write |
| fill_asn_i | input | 8 | ASN to write |
| fill_pfn_i | input | 32 | PFN to write |
| valid_o | output | 1 | Result strobe |
| paddr_o | output | 64 | Physical address |
| fault_o | output | 3 | 0 none, 1 access violation, 2 miss, 3 machine check |
| status_o | output | 3 | {write, bad VA, access violation} |
| rd_access_cnt_o | output | 16 | Translated read accesses |
| wr_access_cnt_o | output | 16 | Translated write accesses |
| rd_hit_cnt_o | output | 16 | Successful reads |
| wr_hit_cnt_o | output | 16 | Successful writes |
| rd_acv_cnt_o | output | 16 | Read access violations |
| wr_acv_cnt_o | output | 16 | Write access violations |

## Verification
Errors in the translation buffer cannot be seen until a lookup touches the affected entry. For example, a stale valid bit, a wrong replacement pointer or a lookup that races a fill shows up only then, as a wrong `paddr_o` or a spurious miss in the cycle after that lookup. The bench therefore fills the buffer past its capacity and revisits evicted and freshly written pages. A counter that increments on the wrong path drifts at its port on the first misclassified request. Because every counter is compared every cycle, such a drift is caught on that very cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_MISS = 3'd2,
    FLT_MCHK = 3'd3
  } fault_e;

  localparam logic [1:0] MODE_KERNEL = 2'b00;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [ASN_W-1:0] lk_asn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [ASN_W-1:0] fill_asn_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i) && (asn_q[g] == lk_asn_i);
  end

  // lowest index wins on duplicate entries
  always_comb begin
    hit_o = |match;
    pfn_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) pfn_o = pfn_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        asn_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else if (fill_en_i) begin
      valid_q[ptr_q] <= 1'b1;
      vpn_q[ptr_q]   <= fill_vpn_i;
      asn_q[ptr_q]   <= fill_asn_i;
      pfn_q[ptr_q]   <= fill_pfn_i;
      ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_decide.sv
module xlate_decide
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_HI     = 42,
  parameter int PG_BITS   = 13,
  parameter int PFN_W     = 32,
  parameter int PA_IMPL_W = 44
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             phys_i,
  input  logic             is_write_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       sp_en_i,
  input  logic             tlb_hit_i,
  input  logic [PFN_W-1:0] tlb_pfn_i,
  output logic [VA_W-1:0]  paddr_o,
  output fault_e           fault_o,
  output logic [2:0]       status_o,
  output logic             translated_o
);
  localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};

  logic            sp_hit, va_ok;
  logic [VA_W-1:0] mapped;

  assign sp_hit = sp_en_i[1] && (va_i[VA_HI:VA_HI-1] == 2'b10);
  // upper bits must sign-extend the top implemented bit
  assign va_ok  = (&va_i[VA_W-1:VA_HI]) || !(|va_i[VA_W-1:VA_HI]);

  always_comb begin
    mapped = '0;
    mapped[PFN_W+PG_BITS-1:0] = {tlb_pfn_i, va_i[PG_BITS-1:0]};
  end

  always_comb begin
    paddr_o      = '0;
    fault_o      = FLT_NONE;
    status_o     = 3'b000;
    translated_o = 1'b0;
    if (sp_hit && (mode_i != MODE_KERNEL)) begin
      fault_o  = FLT_ACV;
      status_o = {is_write_i, 1'b0, 1'b1};
    end else if (sp_hit || phys_i) begin
      paddr_o = va_i & PA_MASK;
    end else begin
      translated_o = 1'b1;
      if (!va_ok) begin
        fault_o  = FLT_ACV;
        status_o = {is_write_i, 1'b1, 1'b1};
      end else if (!tlb_hit_i) begin
        fault_o  = FLT_MISS;
        status_o = {is_write_i, 1'b0, 1'b0};
      end else begin
        paddr_o = mapped;
        if (|(mapped & ~PA_MASK)) fault_o = FLT_MCHK;
      end
    end
  end
endmodule

// File: rtl/xlate_ctr.sv
module xlate_ctr #(
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_acc_i,
  input  logic                  inc_hit_i,
  input  logic                  inc_acv_i,
  input  logic                  wr_i,
  output logic [1:0][CNT_W-1:0] acc_o,
  output logic [1:0][CNT_W-1:0] hit_o,
  output logic [1:0][CNT_W-1:0] acv_o
);
  // index 0 = read, 1 = write
  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic sel;
    assign sel = (wr_i == d[0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_o[d] <= '0;
        hit_o[d] <= '0;
        acv_o[d] <= '0;
      end else if (sel) begin
        if (inc_acc_i) acc_o[d] <= acc_o[d] + 1'b1;
        if (inc_hit_i) hit_o[d] <= hit_o[d] + 1'b1;
        if (inc_acv_i) acv_o[d] <= acv_o[d] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_HI     = 42,
  parameter int PG_BITS   = 13,
  parameter int ASN_W     = 8,
  parameter int PFN_W     = 32,
  parameter int PA_IMPL_W = 44,
  parameter int ENTRIES   = 8,
  parameter int CNT_W     = 16,
  localparam int VPN_W    = VA_HI - PG_BITS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             phys_i,
  input  logic             is_write_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       sp_en_i,
  input  logic [ASN_W-1:0] asn_i,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [ASN_W-1:0] fill_asn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  output logic             valid_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic [2:0]       fault_o,
  output logic [2:0]       status_o,
  output logic [CNT_W-1:0] rd_access_cnt_o,
  output logic [CNT_W-1:0] wr_access_cnt_o,
  output logic [CNT_W-1:0] rd_hit_cnt_o,
  output logic [CNT_W-1:0] wr_hit_cnt_o,
  output logic [CNT_W-1:0] rd_acv_cnt_o,
  output logic [CNT_W-1:0] wr_acv_cnt_o
);
  logic                  tlb_hit;
  logic [PFN_W-1:0]      tlb_pfn;
  logic [VA_W-1:0]       d_paddr;
  fault_e                d_fault;
  logic [2:0]            d_status;
  logic                  d_translated;
  logic [1:0][CNT_W-1:0] acc, hit, acv;

  xlate_tlb #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W)
  ) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_vpn_i   (va_i[VA_HI:PG_BITS]),
    .lk_asn_i   (asn_i),
    .hit_o      (tlb_hit),
    .pfn_o      (tlb_pfn),
    .fill_en_i  (fill_en_i),
    .fill_vpn_i (fill_vpn_i),
    .fill_asn_i (fill_asn_i),
    .fill_pfn_i (fill_pfn_i)
  );

  xlate_decide #(
    .VA_W(VA_W), .VA_HI(VA_HI), .PG_BITS(PG_BITS), .PFN_W(PFN_W), .PA_IMPL_W(PA_IMPL_W)
  ) u_dec (
    .va_i         (va_i),
    .phys_i       (phys_i),
    .is_write_i   (is_write_i),
    .mode_i       (mode_i),
    .sp_en_i      (sp_en_i),
    .tlb_hit_i    (tlb_hit),
    .tlb_pfn_i    (tlb_pfn),
    .paddr_o      (d_paddr),
    .fault_o      (d_fault),
    .status_o     (d_status),
    .translated_o (d_translated)
  );

  xlate_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_acc_i (req_valid_i && d_translated),
    .inc_hit_i (req_valid_i && (d_fault == FLT_NONE)),
    .inc_acv_i (req_valid_i && (d_fault == FLT_ACV)),
    .wr_i      (is_write_i),
    .acc_o     (acc),
    .hit_o     (hit),
    .acv_o     (acv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      paddr_o  <= '0;
      fault_o  <= 3'd0;
      status_o <= 3'd0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        paddr_o  <= d_paddr;
        fault_o  <= d_fault;
        status_o <= d_status;
      end
    end
  end

  assign rd_access_cnt_o = acc[0];
  assign wr_access_cnt_o = acc[1];
  assign rd_hit_cnt_o    = hit[0];
  assign wr_hit_cnt_o    = hit[1];
  assign rd_acv_cnt_o    = acv[0];
  assign wr_acv_cnt_o    = acv[1];
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int VA_W      = 64,
  parameter int PA_IMPL_W = 44,
  parameter int CNT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             valid_o,
  input logic [VA_W-1:0]  paddr_o,
  input logic [2:0]       fault_o,
  input logic [2:0]       status_o,
  input logic [CNT_W-1:0] rd_hit_cnt_o,
  input logic [CNT_W-1:0] wr_access_cnt_o
);
  localparam logic [VA_W-1:0] HI_MASK = ~{{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};

  // R1
  req_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  // R8
  ok_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 3'd0) |-> ((paddr_o & HI_MASK) == '0));
  // R9
  clean_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (fault_o == 3'd0 || fault_o == 3'd3)) |-> (status_o == 3'd0));
  // R9
  acv_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 3'd1) |-> status_o[0]);
  // R12
  hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(rd_hit_cnt_o));
  // R11
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(wr_access_cnt_o));
endmodule

bind addr_xlate_unit xlate_chk #(
  .VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .valid_o         (valid_o),
  .paddr_o         (paddr_o),
  .fault_o         (fault_o),
  .status_o        (status_o),
  .rd_hit_cnt_o    (rd_hit_cnt_o),
  .wr_access_cnt_o (wr_access_cnt_o)
);

// File: tb/tb_addr_xlate_unit.sv
module tb_addr_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MASK = 64'h0000_0FFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] va_i = '0;
  logic        phys_i = 1'b0, is_write_i = 1'b0;
  logic [1:0]  mode_i = '0, sp_en_i = '0;
  logic [7:0]  asn_i = '0;
  logic        fill_en_i = 1'b0;
  logic [29:0] fill_vpn_i = '0;
  logic [7:0]  fill_asn_i = '0;
  logic [31:0] fill_pfn_i = '0;
  logic        valid_o;
  logic [63:0] paddr_o;
  logic [2:0]  fault_o, status_o;
  logic [15:0] rd_acc, wr_acc, rd_hit, wr_hit, rd_acv, wr_acv;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .va_i(va_i),
    .phys_i(phys_i), .is_write_i(is_write_i), .mode_i(mode_i), .sp_en_i(sp_en_i),
    .asn_i(asn_i), .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
    .fill_asn_i(fill_asn_i), .fill_pfn_i(fill_pfn_i), .valid_o(valid_o),
    .paddr_o(paddr_o), .fault_o(fault_o), .status_o(status_o),
    .rd_access_cnt_o(rd_acc), .wr_access_cnt_o(wr_acc), .rd_hit_cnt_o(rd_hit),
    .wr_hit_cnt_o(wr_hit), .rd_acv_cnt_o(rd_acv), .wr_acv_cnt_o(wr_acv)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit          m_v   [8];
  logic [29:0] m_vpn [8];
  logic [7:0]  m_asn [8];
  logic [31:0] m_pfn [8];
  int          m_ptr = 0;
  int          c_acc [2], c_hit [2], c_acv [2];
  logic        e_valid = 0;
  logic [63:0] e_pa = '0;
  logic [2:0]  e_f = '0, e_st = '0;
  string       e_tag = "R2";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 valid", 64'(valid_o), 64'(e_valid));
    chk({e_tag, " paddr"}, paddr_o, e_pa);
    chk({e_tag, " fault"}, 64'(fault_o), 64'(e_f));
    chk("R9 status", 64'(status_o), 64'(e_st));
    chk("R11 rd access", 64'(rd_acc), 64'(16'(c_acc[0])));
    chk("R11 wr access", 64'(wr_acc), 64'(16'(c_acc[1])));
    chk("R12 rd hit", 64'(rd_hit), 64'(16'(c_hit[0])));
    chk("R12 wr hit", 64'(wr_hit), 64'(16'(c_hit[1])));
    chk("R13 rd acv", 64'(rd_acv), 64'(16'(c_acv[0])));
    chk("R13 wr acv", 64'(wr_acv), 64'(16'(c_acv[1])));
  endtask

  task automatic step(input logic rv, input logic [63:0] va, input logic ph, input logic wr,
                      input logic [1:0] md, input logic [1:0] sp, input logic [7:0] asn,
                      input logic fe, input logic [29:0] fv, input logic [7:0] fa,
                      input logic [31:0] fp);
    bit sp_hit, ok, found;
    logic [22:0] up;
    logic [63:0] pa;
    int w;
    req_valid_i = rv; va_i = va; phys_i = ph; is_write_i = wr; mode_i = md;
    sp_en_i = sp; asn_i = asn; fill_en_i = fe; fill_vpn_i = fv; fill_asn_i = fa;
    fill_pfn_i = fp;
    e_valid = rv;
    w = wr ? 1 : 0;
    if (rv) begin
      sp_hit = sp[1] && (va[42:41] == 2'b10);
      if (sp_hit && md != 2'b00) begin
        e_pa = 0; e_f = 1; e_st = {wr, 2'b01}; e_tag = "R4";
      end else if (sp_hit || ph) begin
        e_pa = va & MASK; e_f = 0; e_st = 0; e_tag = sp_hit ? "R3" : "R5";
      end else begin
        c_acc[w]++;
        up = va[63:41] >> 1;
        ok = (va[63:42] == 22'h0) || (va[63:42] == 22'h3FFFFF);
        if (!ok) begin
          e_pa = 0; e_f = 1; e_st = {wr, 2'b11}; e_tag = "R6";
        end else begin
          found = 0; pa = 0;
          for (int i = 0; i < 8; i++)
            if (!found && m_v[i] && m_vpn[i] == va[42:13] && m_asn[i] == asn) begin
              found = 1;
              pa = (64'(m_pfn[i]) << 13) | 64'(va[12:0]);
            end
          if (!found) begin
            e_pa = 0; e_f = 2; e_st = {wr, 2'b00}; e_tag = "R7";
          end else begin
            e_pa = pa; e_st = 0;
            e_f = (pa >> 44) != 0 ? 3'd3 : 3'd0;
            e_tag = (e_f == 3) ? "R8" : "R7";
          end
        end
      end
      if (e_f == 0) c_hit[w]++;
      if (e_f == 1) c_acv[w]++;
    end
    if (fe) begin  // R10 fill after lookup
      m_v[m_ptr] = 1; m_vpn[m_ptr] = fv; m_asn[m_ptr] = fa; m_pfn[m_ptr] = fp;
      m_ptr = (m_ptr + 1) % 8;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic req(input logic [63:0] va, input logic ph, input logic wr,
                     input logic [1:0] md, input logic [1:0] sp, input logic [7:0] asn);
    step(1, va, ph, wr, md, sp, asn, 0, '0, '0, '0);
  endtask

  task automatic fill(input logic [29:0] v, input logic [7:0] a, input logic [31:0] p);
    step(0, '0, 0, 0, 0, 0, 0, 1, v, a, p);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_pfn[i] = 0; end
    for (int i = 0; i < 2; i++) begin c_acc[i] = 0; c_hit[i] = 0; c_acv[i] = 0; end
    repeat (3) @(negedge clk);
    compare();  // R2 reset state
    rst_ni = 1'b1;
    @(negedge clk);
    compare();
    // R2: empty buffer misses
    req(64'(30'h100) << 13, 0, 0, 0, 0, 8'd5);
    // R10: fill 8 entries
    for (int i = 0; i < 7; i++) fill(30'h100 + 30'(i), 8'd5, 32'(i + 1));
    fill(30'h107, 8'd5, 32'h8000_0000);
    // R5 physical, no validity check
    req(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b11, 0, 0);
    // R3 superpage kernel
    req(64'h0000_0400_1234_5678, 0, 1, 0, 2'b10, 0);
    // R6 bit 42 set, upper zero, superpage disabled
    req(64'h0000_0400_1234_5678, 0, 1, 0, 2'b01, 0);
    // R4 superpage user, even with phys set
    req(64'h0000_0400_1234_5678, 1, 1, 2'b10, 2'b10, 0);
    // R7 hit
    req((64'(30'h103) << 13) | 64'h55, 0, 0, 2'b10, 0, 8'd5);
    // R7 ASN mismatch, store
    req((64'(30'h103) << 13) | 64'h55, 0, 1, 2'b10, 0, 8'd6);
    // R8 machine check
    req((64'(30'h107) << 13) | 64'h1FFF, 0, 0, 0, 0, 8'd5);
    // R10 wrap: replaces entry 0; same-cycle lookup sees old contents
    step(1, 64'(30'h500) << 13, 0, 0, 0, 0, 8'd5, 1, 30'h500, 8'd5, 32'h77);
    req(64'(30'h100) << 13, 0, 0, 0, 0, 8'd5);
    req(64'(30'h500) << 13, 0, 1, 0, 0, 8'd5);
    // negative valid VA
    fill(30'h3FFF_FFF0, 8'd1, 32'h12);
    req(64'hFFFF_FFFF_FFFE_0000 | 64'h10, 0, 0, 0, 0, 8'd1);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] va;
      logic [29:0] vpn;
      int k;
      k = $urandom_range(0, 9);
      vpn = {$urandom_range(0, 1) ? 13'h1FFF : 13'h0, 17'($urandom_range(0, 15))};
      va = {{21{vpn[29]}}, vpn, 13'($urandom)};
      if (k == 0) va[63:43] = 21'($urandom);
      if (k == 1) va[42:41] = 2'b10;
      step($urandom_range(0, 3) != 0, va, $urandom_range(0, 7) == 0, 1'($urandom),
           2'($urandom), 2'($urandom), 8'($urandom_range(0, 2)),
           $urandom_range(0, 4) == 0, {{13{vpn[29]}}, 17'($urandom_range(0, 15))},
           8'($urandom_range(0, 2)),
           $urandom_range(0, 5) == 0 ? 32'h8000_0000 | 32'($urandom) : 32'($urandom_range(0, 999)));
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule